// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive path of an Ethernet MAC and decides, once per frame, whether the frame is kept or dropped by looking at its 48-bit destination address. The decision draws on four sources. There are two exact-match station addresses. There is a 512-bin hash table for group addresses, indexed by the top bits of a CRC that is computed elsewhere over the address. Broadcast is always accepted. A promiscuous input overrides every other rule. Alongside each verdict the block reports whether the address was unicast, multicast or broadcast, so that the statistics counters can bin the frame.

The first station address is taken straight from its input ports. The second is captured into the block by a load strobe, and a filter-clear pulse wipes it. The hash table is written one bin per cycle through a control word, and the same clear pulse empties the whole table. A lookup is presented with `addrValid`, and its verdict appears on the registered outputs on the next clock edge.

Top module: `rx_addr_filter`

## Requirements
- R1: When `promisc` is 1 during a lookup, the verdict is accept, whatever the address class and table contents.
- R2: With `promisc` 0, a unicast address (bit 40 clear) is accepted only when it equals station 0 `{sta0Hi,sta0Lo}` or the loaded station 1. The low word is address bits 31:0 and the high word is bits 47:32.
- R3: A station address of all zeros never matches, including when the looked-up address is itself all zeros.
- R4: A hash write takes bits 8:0 of `hashWrData` as the bin and bit 9 as the new value (1 sets, 0 clears). It takes effect at the clock edge, so a lookup in the same cycle sees the bin's previous value.
- R5: With `promisc` 0, a multicast address (bit 40 set, not all ones) is accepted exactly when the bin selected by `addrCrc[31:23]` is set.
- R6: The all-ones address is always accepted and is classed as broadcast.
- R7: `sta1Load` captures `{sta1Hi,sta1Lo}` as station 1. `filterClr` clears every hash bin and station 1, and it overrides a hash write or station load in the same cycle.
- R8: `acceptValid` is 1 exactly one cycle after `addrValid` was 1. `addrClass` is 0 for unicast, 1 for multicast and 2 for broadcast. When no lookup was made, `accept` and `addrClass` are 0.
- R9: After reset, `acceptValid` is 0, every hash bin is clear and station 1 is unprogrammed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrValid | input | 1 | A destination address is presented for lookup |
| dstAddr | input | 48 | Destination address; bit 40 is the group bit |
| addrCrc | input | 32 | CRC over the destination address |
| promisc | input | 1 | Accept all frames |
| sta0Lo | input | 32 | Station 0 address bits 31:0 |
| sta0Hi | input | 16 | Station 0 address bits 47:32 |
| sta1Lo | input | 32 | Station 1 load value, bits 31:0 |
| sta1Hi | input | 16 | Station 1 load value, bits 47:32 |
| sta1Load | input | 1 | Capture station 1 |
| hashWrEn | input | 1 | Write the hash control word |
| hashWrData | input | 10 | Bin index in bits 8:0, new value in bit 9 |
| filterClr | input | 1 | Clear all hash bins and station 1 |
| acceptValid | output | 1 | A verdict is present |
| accept | output | 1 | Keep the frame |
| addrClass | output | 2 | 0 unicast, 1 multicast, 2 broadcast |

## Verification
The table update and the lookup can fall in the same cycle. A hash write to the very bin that a multicast lookup selects is one case. A filter clear together with a lookup that hits either station 1 or a set bin is another. The bench provokes both cases on purpose, and also mixes them at random. Its reference model evaluates every verdict against the table state from before the edge and then applies the update, so a design that forwards the new value into the lookup disagrees on that cycle. A clear that arrives together with a write or a station load is also driven, and the cycles that follow show whether the clear won.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

  typedef enum logic [1:0] {
    CLASS_UCAST = 2'd0,
    CLASS_MCAST = 2'd1,
    CLASS_BCAST = 2'd2
  } addr_class_e;

  // Strobes from the control decoder into the datapath.
  typedef struct packed {
    logic lookup;
    logic binWrite;
    logic binValue;
    logic clearAll;
    logic sta1Capture;
  } filt_strobe_t;

endpackage

// File: rtl/rxaf_ctrl.sv
module rxaf_ctrl
  import rxaf_pkg::*;
#(
  parameter int BIN_W  = 9,
  parameter int CTRL_W = BIN_W + 1
) (
  input  logic              addrValid,
  input  logic              hashWrEn,
  input  logic [CTRL_W-1:0] hashWrData,
  input  logic              filterClr,
  input  logic              sta1Load,
  output filt_strobe_t      strobes,
  output logic [BIN_W-1:0]  wrBin
);

  // The clear takes priority over any single-entry update in the same cycle.
  always_comb begin
    strobes.lookup      = addrValid;
    strobes.clearAll    = filterClr;
    strobes.binWrite    = hashWrEn && !filterClr;
    strobes.binValue    = hashWrData[BIN_W];
    strobes.sta1Capture = sta1Load && !filterClr;
    wrBin               = hashWrData[BIN_W-1:0];
  end

endmodule

// File: rtl/rxaf_datapath.sv
module rxaf_datapath
  import rxaf_pkg::*;
#(
  parameter int ADDR_W    = 48,
  parameter int HASH_BINS = 512,
  parameter int BIN_W     = $clog2(HASH_BINS),
  parameter int GROUP_BIT = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  filt_strobe_t      strobes,
  input  logic [BIN_W-1:0]  wrBin,
  input  logic [BIN_W-1:0]  lookBin,
  input  logic [ADDR_W-1:0] dstAddr,
  input  logic [ADDR_W-1:0] sta0Addr,
  input  logic [ADDR_W-1:0] sta1In,
  input  logic              promisc,
  output logic              acceptValid,
  output logic              accept,
  output logic [1:0]        addrClass
);

  logic [HASH_BINS-1:0] binQ;
  logic [ADDR_W-1:0]    sta1Q;

  // One flop per hash bin, each with its own write decode.
  for (genvar b = 0; b < HASH_BINS; b++) begin : g_bin
    always_ff @(posedge clk) begin
      if (!rstN || strobes.clearAll) begin
        binQ[b] <= 1'b0;
      end else if (strobes.binWrite && wrBin == BIN_W'(b)) begin
        binQ[b] <= strobes.binValue;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clearAll) begin
      sta1Q <= '0;
    end else if (strobes.sta1Capture) begin
      sta1Q <= sta1In;
    end
  end

  logic        isBcast;
  logic        isMcast;
  logic        hit0;
  logic        hit1;
  logic        verdict;
  addr_class_e cls;

  always_comb begin
    isBcast = &dstAddr;
    isMcast = dstAddr[GROUP_BIT] && !isBcast;
    hit0    = (sta0Addr != '0) && (dstAddr == sta0Addr);
    hit1    = (sta1Q != '0) && (dstAddr == sta1Q);
    if (isBcast) begin
      cls = CLASS_BCAST;
    end else if (isMcast) begin
      cls = CLASS_MCAST;
    end else begin
      cls = CLASS_UCAST;
    end
    unique case (cls)
      CLASS_BCAST: verdict = 1'b1;
      CLASS_MCAST: verdict = binQ[lookBin];
      default:     verdict = hit0 || hit1;
    endcase
    verdict = verdict || promisc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acceptValid <= 1'b0;
      accept      <= 1'b0;
      addrClass   <= 2'd0;
    end else begin
      acceptValid <= strobes.lookup;
      accept      <= strobes.lookup && verdict;
      addrClass   <= strobes.lookup ? cls : CLASS_UCAST;
    end
  end

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxaf_pkg::*;
#(
  parameter int ADDR_W    = 48,
  parameter int CRC_W     = 32,
  parameter int HASH_BINS = 512,
  parameter int BIN_W     = $clog2(HASH_BINS),
  parameter int CTRL_W    = BIN_W + 1,
  parameter int LO_W      = 32,
  parameter int HI_W      = ADDR_W - LO_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrValid,
  input  logic [ADDR_W-1:0] dstAddr,
  input  logic [CRC_W-1:0]  addrCrc,
  input  logic              promisc,
  input  logic [LO_W-1:0]   sta0Lo,
  input  logic [HI_W-1:0]   sta0Hi,
  input  logic [LO_W-1:0]   sta1Lo,
  input  logic [HI_W-1:0]   sta1Hi,
  input  logic              sta1Load,
  input  logic              hashWrEn,
  input  logic [CTRL_W-1:0] hashWrData,
  input  logic              filterClr,
  output logic              acceptValid,
  output logic              accept,
  output logic [1:0]        addrClass
);

  filt_strobe_t     strobes;
  logic [BIN_W-1:0] wrBin;
  logic [BIN_W-1:0] lookBin;
  logic             unusedCrcLow;

  // Only the top CRC bits select a bin.
  assign lookBin      = addrCrc[CRC_W-1 -: BIN_W];
  assign unusedCrcLow = ^addrCrc[CRC_W-BIN_W-1:0];

  rxaf_ctrl #(
    .BIN_W  (BIN_W),
    .CTRL_W (CTRL_W)
  ) u_ctrl (
    .addrValid  (addrValid),
    .hashWrEn   (hashWrEn),
    .hashWrData (hashWrData),
    .filterClr  (filterClr),
    .sta1Load   (sta1Load),
    .strobes    (strobes),
    .wrBin      (wrBin)
  );

  rxaf_datapath #(
    .ADDR_W    (ADDR_W),
    .HASH_BINS (HASH_BINS),
    .BIN_W     (BIN_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .wrBin       (wrBin),
    .lookBin     (lookBin),
    .dstAddr     (dstAddr),
    .sta0Addr    ({sta0Hi, sta0Lo}),
    .sta1In      ({sta1Hi, sta1Lo}),
    .promisc     (promisc),
    .acceptValid (acceptValid),
    .accept      (accept),
    .addrClass   (addrClass)
  );

endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk #(
  parameter int ADDR_W = 48,
  parameter int LO_W   = 32,
  parameter int HI_W   = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              addrValid,
  input logic [ADDR_W-1:0] dstAddr,
  input logic              promisc,
  input logic [LO_W-1:0]   sta0Lo,
  input logic [HI_W-1:0]   sta0Hi,
  input logic              acceptValid,
  input logic              accept,
  input logic [1:0]        addrClass
);

  p_promisc_r1: assert property (@(posedge clk) disable iff (!rstN)
    addrValid && promisc |=> accept);

  p_sta0_hit_r2: assert property (@(posedge clk) disable iff (!rstN)
    addrValid && !dstAddr[40] && ({sta0Hi, sta0Lo} != '0) &&
    (dstAddr == {sta0Hi, sta0Lo}) |=> accept && addrClass == 2'd0);

  p_bcast_r6: assert property (@(posedge clk) disable iff (!rstN)
    addrValid && (&dstAddr) |=> accept && addrClass == 2'd2);

  p_valid_lat_r8: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |=> acceptValid);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !addrValid |=> !acceptValid && !accept && addrClass == 2'd0);

  p_mcast_class_r8: assert property (@(posedge clk) disable iff (!rstN)
    addrValid && dstAddr[40] && !(&dstAddr) |=> addrClass == 2'd1);

endmodule

bind rx_addr_filter rx_addr_filter_chk #(
  .ADDR_W (ADDR_W),
  .LO_W   (LO_W),
  .HI_W   (HI_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .addrValid   (addrValid),
  .dstAddr     (dstAddr),
  .promisc     (promisc),
  .sta0Lo      (sta0Lo),
  .sta0Hi      (sta0Hi),
  .acceptValid (acceptValid),
  .accept      (accept),
  .addrClass   (addrClass)
);

// File: tb/tb_rx_addr_filter.sv
`timescale 1ns/1ps
module tb_rx_addr_filter;

  logic        clk = 1'b0;
  logic        rstN;
  logic        addrValid;
  logic [47:0] dstAddr;
  logic [31:0] addrCrc;
  logic        promisc;
  logic [31:0] sta0Lo;
  logic [15:0] sta0Hi;
  logic [31:0] sta1Lo;
  logic [15:0] sta1Hi;
  logic        sta1Load;
  logic        hashWrEn;
  logic [9:0]  hashWrData;
  logic        filterClr;
  logic        acceptValid;
  logic        accept;
  logic [1:0]  addrClass;

  always #2 clk = ~clk;

  rx_addr_filter dut (
    .clk(clk), .rstN(rstN), .addrValid(addrValid), .dstAddr(dstAddr),
    .addrCrc(addrCrc), .promisc(promisc), .sta0Lo(sta0Lo), .sta0Hi(sta0Hi),
    .sta1Lo(sta1Lo), .sta1Hi(sta1Hi), .sta1Load(sta1Load),
    .hashWrEn(hashWrEn), .hashWrData(hashWrData), .filterClr(filterClr),
    .acceptValid(acceptValid), .accept(accept), .addrClass(addrClass)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // Behavioural reference state.
  bit [511:0] refHash;
  bit [47:0]  refSta1;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic quiet();
    addrValid = 0; promisc = 0; sta1Load = 0; hashWrEn = 0;
    filterClr = 0; hashWrData = '0;
  endtask

  // One clock: predict from pre-edge state, update the model, compare after the edge.
  task automatic step(string req);
    bit [47:0] s0;
    bit        bc, mc, hit, expAcc;
    int        expCls;
    s0 = {sta0Hi, sta0Lo};
    bc = &dstAddr;
    mc = dstAddr[40] && !bc;
    expCls = bc ? 2 : (mc ? 1 : 0);
    if (bc) hit = 1;
    else if (mc) hit = refHash[addrCrc[31:23]];
    else hit = (s0 != 0 && dstAddr == s0) || (refSta1 != 0 && dstAddr == refSta1);
    expAcc = addrValid && (hit || promisc);
    if (!addrValid) expCls = 0;
    if (filterClr) begin
      refHash = '0; refSta1 = '0;
    end else begin
      if (hashWrEn) refHash[hashWrData[8:0]] = hashWrData[9];
      if (sta1Load) refSta1 = {sta1Hi, sta1Lo};
    end
    begin
      bit expV;
      expV = addrValid;
      @(posedge clk);
      #1;
      check(req, "acceptValid", acceptValid, expV);
      check(req, "accept", accept, expAcc);
      check(req, "addrClass", addrClass, expCls);
    end
    quiet();
  endtask

  task automatic look(bit [47:0] a, bit [31:0] c, string req);
    addrValid = 1; dstAddr = a; addrCrc = c;
    step(req);
  endtask

  function automatic bit [31:0] crcFor(int bin);
    return {bin[8:0], 23'h1a5a5};
  endfunction

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    quiet();
    dstAddr = '0; addrCrc = '0; sta0Lo = '0; sta0Hi = '0; sta1Lo = '0; sta1Hi = '0;
    refHash = '0; refSta1 = '0;
    rstN = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R9", "acceptValid in reset", acceptValid, 0);
    check("R9", "accept in reset", accept, 0);
    rstN = 1;

    // R9: empty table after reset; R3: zero stations never match a zero address.
    look(48'h0100_0000_0001, crcFor(77), "R9");
    look(48'h0, 32'h0, "R3");

    // R2: station 0 match and miss; R3 with station 0 programmed but station 1 zero.
    sta0Hi = 16'h0022; sta0Lo = 32'h3344_5566;
    look(48'h0022_3344_5566, 32'h0, "R2");
    look(48'h0022_3344_5567, 32'h0, "R2");
    look(48'h0, 32'h0, "R3");

    // R7: load station 1, then hit it.
    sta1Hi = 16'h0a0b; sta1Lo = 32'h0c0d_0e0f; sta1Load = 1;
    look(48'h0a0b_0c0d_0e0f, 32'h0, "R7");
    look(48'h0a0b_0c0d_0e0f, 32'h0, "R2");

    // R4/R5: set bin 300, hit it, miss a neighbour.
    hashWrEn = 1; hashWrData = {1'b1, 9'd300}; step("R4");
    look(48'h0300_0000_0001, crcFor(300), "R5");
    look(48'h0300_0000_0001, crcFor(301), "R5");
    // R4: same-cycle clear of bin 300 with lookup sees old (set) value.
    hashWrEn = 1; hashWrData = {1'b0, 9'd300};
    look(48'h0300_0000_0001, crcFor(300), "R4");
    look(48'h0300_0000_0001, crcFor(300), "R4");
    // R4: same-cycle set with lookup sees old (clear) value.
    hashWrEn = 1; hashWrData = {1'b1, 9'd511};
    look(48'hff00_0000_0000, crcFor(511), "R4");
    look(48'hff00_0000_0000, crcFor(511), "R5");
    hashWrEn = 1; hashWrData = {1'b1, 9'd0}; step("R4");
    look(48'h0100_0000_0000, crcFor(0), "R5");

    // R6: broadcast always accepted, even with empty bin.
    look(48'hffff_ffff_ffff, crcFor(5), "R6");

    // R1: promiscuous accepts unmatched unicast and unset multicast.
    promisc = 1; look(48'h0000_dead_beef, 32'h0, "R1");
    promisc = 1; look(48'h0100_0000_0002, crcFor(3), "R1");

    // R7: clear with same-cycle lookup of station 1 and of a set bin (old state seen).
    filterClr = 1; look(48'h0a0b_0c0d_0e0f, 32'h0, "R7");
    look(48'h0a0b_0c0d_0e0f, 32'h0, "R7");
    look(48'h0100_0000_0000, crcFor(0), "R7");
    look(48'hff00_0000_0000, crcFor(511), "R7");
    // R7: clear beats a same-cycle write and load.
    filterClr = 1; hashWrEn = 1; hashWrData = {1'b1, 9'd42}; sta1Load = 1; step("R7");
    look(48'h0100_0000_0000, crcFor(42), "R7");
    look(48'h0a0b_0c0d_0e0f, 32'h0, "R7");

    // R8: idle cycles keep outputs quiet.
    step("R8"); step("R8");

    // Mixed random traffic, including collisions of updates with lookups.
    for (int i = 0; i < 3000; i++) begin
      int sel;
      string req;
      sel = $urandom_range(0, 9);
      hashWrEn   = ($urandom_range(0, 2) == 0);
      hashWrData = 10'($urandom);
      filterClr  = ($urandom_range(0, 60) == 0);
      sta1Load   = ($urandom_range(0, 40) == 0);
      sta1Hi = ($urandom_range(0, 3) == 0) ? 16'h0 : 16'($urandom);
      sta1Lo = ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom;
      if (sta1Hi != 0) sta1Hi[8] = 1'b0;
      promisc = ($urandom_range(0, 15) == 0);
      addrValid = ($urandom_range(0, 4) != 0);
      addrCrc = $urandom;
      if ($urandom_range(0, 1) == 0) addrCrc[31:23] = hashWrData[8:0];
      case (sel)
        0, 1: begin dstAddr = {sta0Hi, sta0Lo}; req = "R2"; end
        2, 3: begin dstAddr = refSta1; req = "R2"; end
        4:    begin dstAddr = '1; req = "R6"; end
        5, 6, 7: begin dstAddr = {16'($urandom), $urandom}; dstAddr[40] = 1; req = "R5"; end
        default: begin dstAddr = {16'($urandom), $urandom}; dstAddr[40] = 0; req = "R2"; end
      endcase
      if (promisc) req = "R1";
      if (!addrValid) req = "R8";
      step(req);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule